// File: doc/BRIEF.md
# Register and Memory Taint Tracker

This block follows the security level of data as a host processor runs. It holds one tag per architectural register and one tag per word of a small, direct-mapped table of data addresses. An outside agent reports every executed instruction as a rule that was prepared ahead of time. The rule names the kind of operation, the destination register, up to two source registers, the memory address the instruction resolved, and an identifier for its code location. The block never decodes instructions. It only applies the rule it is given to its tag state.

Tag zero means public. Any nonzero value is a private level, and a higher value is more restrictive, so the tag width sets how many levels there are. Tags for data that enters the system from outside, such as file contents returned by a system call, are loaded through a separate initialisation port. A sink rule marks a checked destination, such as an output call or the saved return address. When the data at a sink is not public, the block raises a violation flag. The flag stays set until it is cleared, and it records which rule raised it.

Top module: `ttp_unit`

## Requirements
- R1: After reset, every register tag and every memory tag reads 0, `violation` is low and `violRuleId` is 0.
- R2: An accepted ALU rule (`ruleOp` = 0) writes its destination tag according to `ruleMode`: 0 gives the larger of the two source tags, 1 copies source A, 2 copies source B, and 3 gives 0.
- R3: No rule ever changes the tag of register index 15, the program counter. This holds even when a rule names index 15 as its destination.
- R4: An accepted load rule (`ruleOp` = 1) writes to its destination the larger of two tags: the memory tag at `memAddr[9:2]` and the tag of source register A, which is the index register. A tainted index therefore taints the result even when the memory word is public.
- R5: An accepted store rule (`ruleOp` = 2) copies the tag of source register A into the memory tag at `memAddr[9:2]`. Addresses that differ only outside bits [9:2] share one entry, and other entries are left unchanged.
- R6: While `initValid` is high, `initTag` is written to register `initReg` (when `initToMem` = 0) or to the memory entry at `initAddr[9:2]` (when `initToMem` = 1). During that cycle `ruleReady` is low and any offered rule is not applied.
- R7: An accepted sink rule (`ruleOp` = 3) whose source register A has a nonzero tag raises `violation` in the next cycle and captures `ruleId` in `violRuleId`. A sink whose source tag is 0 raises nothing.
- R8: Once set, `violation` stays high and `violRuleId` keeps the identifier of the first offending rule until a clear, even when later sinks also offend.
- R9: `violClr` drops `violation` in the next cycle. The exception is a private sink accepted in the same cycle: then `violation` stays high and `violRuleId` takes that sink's identifier.
- R10: `rdTag` returns, within the same cycle, the register tag at `rdReg` (when `rdToMem` = 0) or the memory tag at `rdAddr[9:2]` (when `rdToMem` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ruleValid | input | 1 | A rule is offered |
| ruleReady | output | 1 | The rule is accepted this cycle |
| ruleOp | input | 2 | Operation: 0 ALU, 1 load, 2 store, 3 sink |
| ruleMode | input | 2 | Combine mode for ALU rules |
| ruleDst | input | 4 | Destination register index |
| ruleSrcA | input | 4 | Source A: operand, load index, store value, or sink data |
| ruleSrcB | input | 4 | Source B: second ALU operand |
| ruleId | input | 8 | Identifier of the rule's code location |
| memAddr | input | 32 | Resolved address for loads and stores |
| initValid | input | 1 | Tag initialisation write |
| initToMem | input | 1 | 1 writes a memory tag, 0 writes a register tag |
| initReg | input | 4 | Register index to initialise |
| initAddr | input | 32 | Address to initialise |
| initTag | input | 2 | Tag value to write |
| rdToMem | input | 1 | 1 reads a memory tag, 0 reads a register tag |
| rdReg | input | 4 | Register index to read |
| rdAddr | input | 32 | Address to read |
| rdTag | output | 2 | Tag read result |
| violClr | input | 1 | Clears the violation flag |
| violation | output | 1 | Sticky violation flag |
| violRuleId | output | 8 | Identifier of the rule that raised the violation |

## Verification
The ALU combine is swept over every pair of source tags under every mode. This separates a true maximum from a bitwise OR, from a plain copy of one side, and from a swap of the two sources. The load is swept over every pairing of memory tag and index tag, which shows whether both contributions reach the result. The store is checked with one tag written through an aliasing address and a neighbouring entry that must stay untouched. A collision between a rule and an initialisation write shows which of the two owns the cycle. The violation sequences cover a public sink, a first private sink and a second one, a plain clear, and a clear that coincides with a new private sink. Together these separate a set-wins policy from a clear-wins policy, and separate first-identifier capture from last-identifier capture.

// File: rtl/ttp_pkg.sv
package ttp_pkg;
  typedef enum logic [1:0] {
    OP_ALU   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_SINK  = 2'd3
  } ruleOp_e;

  typedef enum logic [1:0] {
    CMB_MAX    = 2'd0,
    CMB_SRCA   = 2'd1,
    CMB_SRCB   = 2'd2,
    CMB_PUBLIC = 2'd3
  } combine_e;

  // strobes from control to datapath
  typedef struct packed {
    logic regWe;
    logic memWe;
    logic sinkChk;
    logic selLoad;
    logic initRegWe;
    logic initMemWe;
  } strobes_t;
endpackage

// File: rtl/ttp_ctrl.sv
module ttp_ctrl
  import ttp_pkg::*;
(
  input  logic       ruleValid,
  input  logic [1:0] ruleOp,
  input  logic       initValid,
  input  logic       initToMem,
  output logic       ruleReady,
  output strobes_t   strb
);
  logic accept;

  always_comb begin
    ruleReady = !initValid;
    accept    = ruleValid && ruleReady;
    strb      = '0;
    case (ruleOp_e'(ruleOp))
      OP_ALU:   strb.regWe = accept;
      OP_LOAD: begin
        strb.regWe   = accept;
        strb.selLoad = 1'b1;
      end
      OP_STORE: strb.memWe = accept;
      OP_SINK:  strb.sinkChk = accept;
      default: ;
    endcase
    strb.initRegWe = initValid && !initToMem;
    strb.initMemWe = initValid && initToMem;
  end
endmodule

// File: rtl/ttp_datapath.sv
module ttp_datapath
  import ttp_pkg::*;
#(
  parameter int TAG_W  = 2,
  parameter int REG_N  = 16,
  parameter int MEM_N  = 256,
  parameter int ADDR_W = 32,
  parameter int RID_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strb,
  input  logic [1:0]               ruleMode,
  input  logic [$clog2(REG_N)-1:0] ruleDst,
  input  logic [$clog2(REG_N)-1:0] ruleSrcA,
  input  logic [$clog2(REG_N)-1:0] ruleSrcB,
  input  logic [RID_W-1:0]         ruleId,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic [$clog2(REG_N)-1:0] initReg,
  input  logic [ADDR_W-1:0]        initAddr,
  input  logic [TAG_W-1:0]         initTag,
  input  logic                     rdToMem,
  input  logic [$clog2(REG_N)-1:0] rdReg,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [TAG_W-1:0]         rdTag,
  input  logic                     violClr,
  output logic                     violation,
  output logic [RID_W-1:0]         violRuleId
);
  localparam int REG_W   = $clog2(REG_N);
  localparam int MEM_IW  = $clog2(MEM_N);
  localparam int MEM_LSB = 2;
  localparam int PC_IDX  = REG_N - 1;

  logic [TAG_W-1:0] regTag [REG_N];
  logic [TAG_W-1:0] memTag [MEM_N];
  logic [TAG_W-1:0] tagA, tagB, aluTag, wrTag, ldMem;
  logic [MEM_IW-1:0] ruleIdx, initIdx, rdIdx;
  logic sinkHit;
  logic unusedAddrBits;

  function automatic logic [TAG_W-1:0] tagMax(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign ruleIdx = memAddr[MEM_LSB +: MEM_IW];
  assign initIdx = initAddr[MEM_LSB +: MEM_IW];
  assign rdIdx   = rdAddr[MEM_LSB +: MEM_IW];
  assign unusedAddrBits = ^{memAddr[ADDR_W-1:MEM_LSB+MEM_IW], memAddr[MEM_LSB-1:0],
                            initAddr[ADDR_W-1:MEM_LSB+MEM_IW], initAddr[MEM_LSB-1:0],
                            rdAddr[ADDR_W-1:MEM_LSB+MEM_IW], rdAddr[MEM_LSB-1:0]};

  assign tagA  = regTag[ruleSrcA];
  assign tagB  = regTag[ruleSrcB];
  assign ldMem = memTag[ruleIdx];

  always_comb begin
    case (combine_e'(ruleMode))
      CMB_MAX:  aluTag = tagMax(tagA, tagB);
      CMB_SRCA: aluTag = tagA;
      CMB_SRCB: aluTag = tagB;
      default:  aluTag = '0;
    endcase
    wrTag = strb.selLoad ? tagMax(ldMem, tagA) : aluTag;
  end

  // register tag file; the program counter entry has no rule write path
  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    if (i == PC_IDX) begin : g_pc
      always_ff @(posedge clk) begin
        if (!rstN) regTag[i] <= '0;
        else if (strb.initRegWe && initReg == REG_W'(i)) regTag[i] <= initTag;
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (!rstN) regTag[i] <= '0;
        else if (strb.initRegWe && initReg == REG_W'(i)) regTag[i] <= initTag;
        else if (strb.regWe && ruleDst == REG_W'(i)) regTag[i] <= wrTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < MEM_N; j++) memTag[j] <= '0;
    end else if (strb.initMemWe) begin
      memTag[initIdx] <= initTag;
    end else if (strb.memWe) begin
      memTag[ruleIdx] <= tagA;
    end
  end

  assign sinkHit = strb.sinkChk && (tagA != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violation  <= 1'b0;
      violRuleId <= '0;
    end else if (sinkHit && (!violation || violClr)) begin
      violation  <= 1'b1;
      violRuleId <= ruleId;
    end else if (violClr) begin
      violation  <= 1'b0;
    end
  end

  assign rdTag = rdToMem ? memTag[rdIdx] : regTag[rdReg];
endmodule

// File: rtl/ttp_unit.sv
module ttp_unit
  import ttp_pkg::*;
#(
  parameter int TAG_W  = 2,
  parameter int REG_N  = 16,
  parameter int MEM_N  = 256,
  parameter int ADDR_W = 32,
  parameter int RID_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ruleValid,
  output logic                     ruleReady,
  input  logic [1:0]               ruleOp,
  input  logic [1:0]               ruleMode,
  input  logic [$clog2(REG_N)-1:0] ruleDst,
  input  logic [$clog2(REG_N)-1:0] ruleSrcA,
  input  logic [$clog2(REG_N)-1:0] ruleSrcB,
  input  logic [RID_W-1:0]         ruleId,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic                     initValid,
  input  logic                     initToMem,
  input  logic [$clog2(REG_N)-1:0] initReg,
  input  logic [ADDR_W-1:0]        initAddr,
  input  logic [TAG_W-1:0]         initTag,
  input  logic                     rdToMem,
  input  logic [$clog2(REG_N)-1:0] rdReg,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [TAG_W-1:0]         rdTag,
  input  logic                     violClr,
  output logic                     violation,
  output logic [RID_W-1:0]         violRuleId
);
  strobes_t strb;

  ttp_ctrl u_ctrl (
    .ruleValid(ruleValid), .ruleOp(ruleOp), .initValid(initValid),
    .initToMem(initToMem), .ruleReady(ruleReady), .strb(strb)
  );

  ttp_datapath #(
    .TAG_W(TAG_W), .REG_N(REG_N), .MEM_N(MEM_N), .ADDR_W(ADDR_W), .RID_W(RID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ruleMode(ruleMode), .ruleDst(ruleDst),
    .ruleSrcA(ruleSrcA), .ruleSrcB(ruleSrcB), .ruleId(ruleId), .memAddr(memAddr),
    .initReg(initReg), .initAddr(initAddr), .initTag(initTag), .rdToMem(rdToMem),
    .rdReg(rdReg), .rdAddr(rdAddr), .rdTag(rdTag), .violClr(violClr),
    .violation(violation), .violRuleId(violRuleId)
  );
endmodule

// File: rtl/ttp_unit_chk.sv
module ttp_unit_chk #(
  parameter int TAG_W = 2,
  parameter int REG_N = 16,
  parameter int RID_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     ruleValid,
  input logic                     ruleReady,
  input logic [1:0]               ruleOp,
  input logic                     initValid,
  input logic                     violClr,
  input logic                     violation,
  input logic [RID_W-1:0]         violRuleId,
  input logic                     rdToMem,
  input logic [$clog2(REG_N)-1:0] rdReg,
  input logic [TAG_W-1:0]         rdTag
);
  localparam int REG_W = $clog2(REG_N);
  logic sinkTaken, pcRead;
  assign sinkTaken = ruleValid && ruleReady && ruleOp == 2'd3;
  assign pcRead    = !rdToMem && rdReg == REG_W'(REG_N - 1);

  AST_INIT_BLOCKS_RULE: assert property (@(posedge clk) disable iff (!rstN)
    initValid |-> !ruleReady); // R6
  AST_VIOL_FROM_SINK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(violation) |-> $past(sinkTaken)); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !violClr) |=> violation); // R8
  AST_VIOL_ID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !violClr) |=> $stable(violRuleId)); // R8
  AST_VIOL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (violClr && !sinkTaken) |=> !violation); // R9
  AST_PC_TAG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (pcRead && $past(pcRead) && !$past(initValid)) |-> $stable(rdTag)); // R3
endmodule

bind ttp_unit ttp_unit_chk #(.TAG_W(TAG_W), .REG_N(REG_N), .RID_W(RID_W)) u_chk (
  .clk(clk), .rstN(rstN), .ruleValid(ruleValid), .ruleReady(ruleReady), .ruleOp(ruleOp),
  .initValid(initValid), .violClr(violClr), .violation(violation), .violRuleId(violRuleId),
  .rdToMem(rdToMem), .rdReg(rdReg), .rdTag(rdTag)
);

// File: tb/ttp_unit_bench.sv
`timescale 1ns/1ps
module ttp_unit_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic ruleValid = 0, initValid = 0, initToMem = 0, rdToMem = 0, violClr = 0;
  logic ruleReady, violation;
  logic [1:0] ruleOp = 0, ruleMode = 0, initTag = 0, rdTag;
  logic [3:0] ruleDst = 0, ruleSrcA = 0, ruleSrcB = 0, initReg = 0, rdReg = 0;
  logic [7:0] ruleId = 0, violRuleId;
  logic [31:0] memAddr = 0, initAddr = 0, rdAddr = 0;
  int nVec = 0, nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ttp_unit u_ttp_unit (.*);

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rdR(input int r, output int t);
    rdToMem = 0; rdReg = 4'(r); #1; t = int'(rdTag);
  endtask

  task automatic rdM(input logic [31:0] a, output int t);
    rdToMem = 1; rdAddr = a; #1; t = int'(rdTag);
  endtask

  task automatic setReg(input int r, input int t);
    @(negedge clk); initValid = 1; initToMem = 0; initReg = 4'(r); initTag = 2'(t);
    @(negedge clk); initValid = 0;
  endtask

  task automatic setMem(input logic [31:0] a, input int t);
    @(negedge clk); initValid = 1; initToMem = 1; initAddr = a; initTag = 2'(t);
    @(negedge clk); initValid = 0;
  endtask

  task automatic rule(input int op, input int md, input int d, input int a, input int b,
                      input logic [31:0] ad, input int id, input bit clr);
    @(negedge clk);
    ruleValid = 1; ruleOp = 2'(op); ruleMode = 2'(md); ruleDst = 4'(d);
    ruleSrcA = 4'(a); ruleSrcB = 4'(b); memAddr = ad; ruleId = 8'(id); violClr = clr;
    @(negedge clk); ruleValid = 0; violClr = 0;
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int t, e;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 16; r++) begin rdR(r, t); chk("R1 reg", t, 0); end
    for (int k = 0; k < 256; k += 17) begin rdM(32'(k * 4), t); chk("R1 mem", t, 0); end
    chk("R1 violation", int'(violation), 0);
    chk("R1 id", int'(violRuleId), 0);

    // R2 exhaustive ALU combine
    for (int ta = 0; ta < 4; ta++)
      for (int tb = 0; tb < 4; tb++)
        for (int md = 0; md < 4; md++) begin
          setReg(1, ta); setReg(2, tb); setReg(3, 1);
          rule(0, md, 3, 1, 2, 0, 0, 0);
          e = (md == 0) ? mx(ta, tb) : (md == 1) ? ta : (md == 2) ? tb : 0;
          rdR(3, t); chk("R2 alu", t, e);
          rdR(10, t); chk("R10 untouched reg", t, 0);
        end

    // R3 program counter tag
    setReg(1, 3); setReg(2, 2); setMem(32'h80, 3);
    rule(0, 0, 15, 1, 2, 0, 0, 0);
    rdR(15, t); chk("R3 alu to pc", t, 0);
    rule(1, 0, 15, 1, 2, 32'h80, 0, 0);
    rdR(15, t); chk("R3 load to pc", t, 0);

    // R4 load sweep
    for (int tm = 0; tm < 4; tm++)
      for (int ti = 0; ti < 4; ti++) begin
        setMem(32'h100, tm); setReg(4, ti); setReg(5, 0);
        rule(1, 0, 5, 4, 0, 32'h100, 0, 0);
        rdR(5, t); chk("R4 load", t, mx(tm, ti));
      end

    // R5 store, aliasing and neighbour
    for (int tv = 0; tv < 4; tv++) begin
      setReg(6, tv); setMem(32'h44, 0);
      rule(2, 0, 0, 6, 0, 32'h440, 0, 0);
      rdM(32'h40, t); chk("R5 store alias", t, tv);
      rdM(32'h43, t); chk("R10 byte offset", t, tv);
      rdM(32'h44, t); chk("R5 neighbour", t, 0);
    end

    // R6 init wins over an offered rule
    setReg(7, 2); setReg(8, 0);
    @(negedge clk);
    initValid = 1; initToMem = 0; initReg = 4'd7; initTag = 2'd1;
    ruleValid = 1; ruleOp = 2'd0; ruleMode = 2'd3; ruleDst = 4'd8; ruleSrcA = 0; ruleSrcB = 0;
    #1 chk("R6 ready low", int'(ruleReady), 0);
    @(negedge clk); initValid = 0; ruleValid = 0;
    #1 chk("R6 ready back", int'(ruleReady), 1);
    rdR(7, t); chk("R6 init reg", t, 1);
    setReg(8, 2);
    @(negedge clk);
    initValid = 1; initToMem = 1; initAddr = 32'h200; initTag = 2'd3;
    ruleValid = 1; ruleOp = 2'd0; ruleMode = 2'd3; ruleDst = 4'd8;
    @(negedge clk); initValid = 0; ruleValid = 0;
    rdR(8, t); chk("R6 rule not applied", t, 2);
    rdM(32'h200, t); chk("R6 init mem", t, 3);

    // R7..R9 violation behaviour
    setReg(9, 0); setReg(10, 2);
    rule(3, 0, 0, 9, 0, 0, 8'h11, 0);
    chk("R7 public sink", int'(violation), 0);
    rule(3, 0, 0, 10, 0, 0, 8'h42, 0);
    chk("R7 private sink", int'(violation), 1);
    chk("R7 id", int'(violRuleId), 8'h42);
    rule(3, 0, 0, 10, 0, 0, 8'h43, 0);
    chk("R8 sticky", int'(violation), 1);
    chk("R8 first id kept", int'(violRuleId), 8'h42);
    rule(3, 0, 0, 9, 0, 0, 8'h44, 1);
    chk("R9 cleared", int'(violation), 0);
    rule(3, 0, 0, 10, 0, 0, 8'h50, 0);
    rule(3, 0, 0, 10, 0, 0, 8'h51, 1);
    chk("R9 clear with sink", int'(violation), 1);
    chk("R9 new id", int'(violRuleId), 8'h51);
    @(negedge clk); violClr = 1;
    @(negedge clk); violClr = 0;
    chk("R9 plain clear", int'(violation), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule